// File: doc/BRIEF.md
# Serial Command Frame Receiver with Chain and Readback Output

This block is the serial front end of a four-channel converter's control logic. A host drives a serial clock, an active-low frame select and a data line. While frame select is low, one bit is taken on every falling serial clock edge, most significant bit first, into a 24-bit shift register. When frame select rises after a whole number of 24-bit groups, the last 24 bits received are handed to the register logic as a one-cycle command: a 4-bit opcode, a 4-bit channel mask and a 16-bit value. If the count is anything else, the frame is dropped.

One serial output serves two purposes. In chain mode it repeats the input stream 24 bit periods late, so the word shifted in during one frame comes out during the next frame. A downstream device can take it in on the falling edge. In readback mode, a read-request frame makes the register logic present a 24-bit value, and the next frame shifts that value out. The block runs entirely on a fast system clock. The three serial inputs pass through two-flop synchronisers, and their edges are detected in that clock domain.

Top module: `spi_frame_rx`

## Requirements
- R1: After reset, `cmd_valid_o` is 0, `miso_o` is 0 and chain mode is off.
- R2: A frame of exactly 24 bits gives exactly one single-cycle `cmd_valid_o` pulse after frame select rises. The received word is sampled on falling serial clock edges, MSB first, and is split as opcode = bits [23:20], channel mask = bits [19:16], value = bits [15:0].
- R3: A frame whose bit count is zero or not a multiple of 24 gives no `cmd_valid_o` pulse.
- R4: When frame select stays low across several 24-bit groups, the command word is the last 24 bits received.
- R5: Opcode 4'h8 sets chain mode to value bit [0]. While chain mode is off and no readback is pending, `miso_o` stays 0.
- R6: In chain mode, the bit sampled on the i-th falling serial clock edge of a frame (i counted from 0) is bit 23-i of the previous 24-bit group. `miso_o` changes only after rising serial clock edges or at frame boundaries.
- R7: Opcode 4'h9 is a read request. `rd_data_i` is captured in the cycle in which `cmd_valid_o` is high. During the next frame, that value is shifted out MSB first, and it takes priority over chain mode.
- R8: At the end of the frame that follows a read request, the output returns to chain behaviour, or to 0 if chain mode is off.
- R9: Serial clock edges while frame select is high shift nothing and do not change `miso_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; idles high |
| csn_i | input | 1 | Active-low frame select |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out (chain or readback) |
| rd_data_i | input | 24 | Readback value from the register logic, selected by `cmd_chan_o` |
| cmd_valid_o | output | 1 | One-cycle pulse: a complete command is present |
| cmd_code_o | output | 4 | Opcode, word bits [23:20] |
| cmd_chan_o | output | 4 | Channel mask, word bits [19:16] |
| cmd_data_o | output | 16 | Value, word bits [15:0] |

## Verification
An incorrect bit counter shows up within three system clocks of frame select rising. It appears as a missing or extra `cmd_valid_o` pulse, or as a word shifted by some bits. A faulty chain or readback register is visible on the serial output from the first falling serial clock edge of the following frame. Because every output bit is compared, a single wrong or misplaced bit names the position where the internal state diverged. An error in the mode flag appears as a non-zero output while the flag should be off. It also appears as an all-zero stream where chained data was expected.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
    localparam int FRAME_W = 24;
    localparam int CODE_W  = 4;
    localparam int CHAN_W  = 4;
    localparam int DATA_W  = FRAME_W - CODE_W - CHAN_W;
    localparam int CNT_W   = $clog2(FRAME_W);

    localparam logic [CODE_W-1:0] OP_CHAIN = 4'h8;
    localparam logic [CODE_W-1:0] OP_READ  = 4'h9;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CHAN_W-1:0] chan;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
    parameter int           W    = 3,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: IDLE, s2: IDLE, s3: IDLE};
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.s2;

    for (genvar g = 0; g < W; g++) begin : g_edge
        assign rise_o[g] =  st_q.s2[g] & ~st_q.s3[g];
        assign fall_o[g] = ~st_q.s2[g] &  st_q.s3[g];
    end
endmodule

// File: rtl/spi_rx_deser.sv
module spi_rx_deser
    import spi_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csn_low_i,
    input  logic               csn_fall_i,
    input  logic               csn_rise_i,
    input  logic               sclk_fall_i,
    input  logic               mosi_i,
    output logic               in_msb_o,
    output logic               vld_o,
    output frame_t             word_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sreg;
        logic [CNT_W-1:0]   cnt;
        logic               any;
        logic               vld;
        frame_t             word;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (csn_fall_i) begin
            st_d.cnt = '0;
            st_d.any = 1'b0;
        end
        if (sclk_fall_i && csn_low_i) begin
            st_d.sreg = {st_q.sreg[FRAME_W-2:0], mosi_i};
            st_d.cnt  = (st_q.cnt == LAST) ? '0 : st_q.cnt + CNT_W'(1);
            st_d.any  = 1'b1;
        end
        if (csn_rise_i) begin
            if (st_q.any && st_q.cnt == '0) begin
                st_d.vld  = 1'b1;
                st_d.word = frame_t'(st_q.sreg);
            end
            st_d.cnt = '0;
            st_d.any = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_msb_o = st_q.sreg[FRAME_W-1];
    assign vld_o    = st_q.vld;
    assign word_o   = st_q.word;

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !csn_low_i |=> $stable(st_q.sreg));

    p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |=> !st_q.vld);
endmodule

// File: rtl/spi_rx_tx.sv
module spi_rx_tx
    import spi_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csn_low_i,
    input  logic               csn_rise_i,
    input  logic               sclk_rise_i,
    input  logic               in_msb_i,
    input  logic               cmd_valid_i,
    input  frame_t             cmd_i,
    input  logic [FRAME_W-1:0] rd_data_i,
    output logic               miso_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] sreg;
        logic               miso;
        logic               rb;
        logic               chain;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (cmd_valid_i && cmd_i.code == OP_CHAIN) begin
            st_d.chain = cmd_i.data[0];
            st_d.miso  = cmd_i.data[0] & in_msb_i;
        end
        if (cmd_valid_i && cmd_i.code == OP_READ) begin
            st_d.rb   = 1'b1;
            st_d.sreg = rd_data_i;
            st_d.miso = rd_data_i[FRAME_W-1];
        end
        if (csn_rise_i) begin
            st_d.rb   = 1'b0;
            st_d.miso = st_q.chain & in_msb_i;
        end
        if (sclk_rise_i && csn_low_i) begin
            if (st_q.rb) begin
                st_d.miso = st_q.sreg[FRAME_W-2];
                st_d.sreg = {st_q.sreg[FRAME_W-2:0], 1'b0};
            end else begin
                st_d.miso = st_q.chain & in_msb_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miso_o = st_q.miso;

    p_quiet_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.chain && !st_q.rb) |-> !st_q.miso);

    p_rb_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rb) |-> $past(cmd_valid_i && cmd_i.code == OP_READ));

    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise_i && !csn_rise_i && !cmd_valid_i) |=> $stable(st_q.miso));
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import spi_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_i,
    input  logic               csn_i,
    input  logic               mosi_i,
    output logic               miso_o,
    input  logic [FRAME_W-1:0] rd_data_i,
    output logic               cmd_valid_o,
    output logic [CODE_W-1:0]  cmd_code_o,
    output logic [CHAN_W-1:0]  cmd_chan_o,
    output logic [DATA_W-1:0]  cmd_data_o
);
    localparam int IX_SCLK = 0;
    localparam int IX_CSN  = 1;
    localparam int IX_MOSI = 2;

    logic [2:0] lvl, rise, fall;
    logic       in_msb;
    logic       vld;
    frame_t     word;

    spi_rx_sync #(.W(3), .IDLE(3'b011)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({mosi_i, csn_i, sclk_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    spi_rx_deser u_deser (
        .clk         (clk),
        .rst_n       (rst_n),
        .csn_low_i   (~lvl[IX_CSN]),
        .csn_fall_i  (fall[IX_CSN]),
        .csn_rise_i  (rise[IX_CSN]),
        .sclk_fall_i (fall[IX_SCLK]),
        .mosi_i      (lvl[IX_MOSI]),
        .in_msb_o    (in_msb),
        .vld_o       (vld),
        .word_o      (word)
    );

    spi_rx_tx u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .csn_low_i   (~lvl[IX_CSN]),
        .csn_rise_i  (rise[IX_CSN]),
        .sclk_rise_i (rise[IX_SCLK]),
        .in_msb_i    (in_msb),
        .cmd_valid_i (vld),
        .cmd_i       (word),
        .rd_data_i   (rd_data_i),
        .miso_o      (miso_o)
    );

    assign cmd_valid_o = vld;
    assign cmd_code_o  = word.code;
    assign cmd_chan_o  = word.chan;
    assign cmd_data_o  = word.data;

    p_valid_csn_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> lvl[IX_CSN]);
endmodule

// File: tb/spi_frame_rx_test.sv
`timescale 1ns/1ps
module spi_frame_rx_test;
    localparam int HALF = 8;
    localparam int GAP  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        csn = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [23:0] rd_data;
    logic        cmd_valid;
    logic [3:0]  cmd_code, cmd_chan;
    logic [15:0] cmd_data;

    int          n_chk = 0;
    int          n_bad = 0;
    int          vcnt = 0;
    logic [23:0] last_word = '0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [23:0] rdv(input logic [3:0] c);
        return {8'hC3, c, ~c, 8'h5A};
    endfunction

    assign rd_data = rdv(cmd_chan);

    spi_frame_rx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk),
        .csn_i       (csn),
        .mosi_i      (mosi),
        .miso_o      (miso),
        .rd_data_i   (rd_data),
        .cmd_valid_o (cmd_valid),
        .cmd_code_o  (cmd_code),
        .cmd_chan_o  (cmd_chan),
        .cmd_data_o  (cmd_data)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            vcnt      <= vcnt + 1;
            last_word <= {cmd_code, cmd_chan, cmd_data};
        end
    end

    typedef struct packed {
        logic [47:0] bits;
        logic [5:0]  n;
        logic        vld;
        logic [23:0] word;
    } vec_t;

    localparam vec_t TBL [7] = '{
        '{48'h312345,        6'd24, 1'b1, 24'h312345},
        '{48'hF0ABCD,        6'd24, 1'b1, 24'hF0ABCD},
        '{48'h0ABCDE,        6'd23, 1'b0, 24'h000000},
        '{48'h1234567,       6'd25, 1'b0, 24'h000000},
        '{48'h1111112A5A5A,  6'd48, 1'b1, 24'h2A5A5A},
        '{48'h0,             6'd0,  1'b0, 24'h000000},
        '{48'h7FFFFF,        6'd24, 1'b1, 24'h7FFFFF}
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [47:0] bits, input int n, output logic [47:0] got);
        got = '0;
        csn = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < n; i++) begin
            mosi = bits[n-1-i];
            wait_clk(HALF);
            got[n-1-i] = miso;
            sclk = 1'b0;
            wait_clk(HALF);
            sclk = 1'b1;
        end
        wait_clk(HALF);
        csn = 1'b1;
        wait_clk(GAP);
    endtask

    task automatic frame(input logic [47:0] bits, input int n, input bit exp_vld,
                         input logic [23:0] exp_word, input logic [47:0] exp_out,
                         input string req_cmd, input string req_out);
        logic [47:0] got;
        int v0;
        v0 = vcnt;
        xfer(bits, n, got);
        chk((vcnt - v0) == (exp_vld ? 1 : 0), {req_cmd, " pulse count"}, 48'(vcnt - v0), 48'(exp_vld));
        if (exp_vld)
            chk(last_word == exp_word, {req_cmd, " word"}, 48'(last_word), 48'(exp_word));
        chk(got == exp_out, {req_out, " serial out"}, got, exp_out);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        // R1: reset state
        chk(cmd_valid == 1'b0 && miso == 1'b0 && vcnt == 0, "R1 reset",
            {46'd0, cmd_valid, miso}, 48'd0);

        // R2/R3/R4 table, chain off so output stays low (R5)
        foreach (TBL[k]) begin
            frame(TBL[k].bits, int'(TBL[k].n), TBL[k].vld, TBL[k].word, 48'd0,
                  "R2/R3/R4 table", "R5 quiet");
        end

        // R9: clock toggles with frame select high
        begin
            int v0;
            v0 = vcnt;
            for (int i = 0; i < 5; i++) begin
                mosi = 1'b1; sclk = 1'b0; wait_clk(HALF);
                sclk = 1'b1; wait_clk(HALF);
            end
            wait_clk(GAP);
            chk(vcnt == v0 && miso == 1'b0, "R9 idle clocks", {47'd0, miso}, 48'd0);
        end
        frame(48'h43BEEF, 24, 1'b1, 24'h43BEEF, 48'd0, "R9 after idle clocks", "R9 out");

        // R5/R6: enable chain, then pass-through
        frame(48'h800001, 24, 1'b1, 24'h800001, 48'd0, "R5 enable", "R5 still quiet");
        frame(48'h512222, 24, 1'b1, 24'h512222, 48'h800001, "R2 chain frame", "R6 chain");
        frame(48'h623333744444, 48, 1'b1, 24'h744444, 48'h512222623333, "R4 long frame", "R6 long chain");

        // R7/R8: readback with chain on
        frame(48'h920000, 24, 1'b1, 24'h920000, 48'h744444, "R7 read request", "R6 before read");
        frame(48'h000000, 24, 1'b1, 24'h000000, {24'd0, rdv(4'h2)}, "R2 nop", "R7 readback");
        frame(48'h001234, 24, 1'b1, 24'h001234, 48'h000000, "R2 after read", "R8 back to chain");

        // R5: disable chain, output returns to zero
        frame(48'h800000, 24, 1'b1, 24'h800000, 48'h001234, "R5 disable", "R6 last chain");
        frame(48'h111111, 24, 1'b1, 24'h111111, 48'd0, "R2 plain", "R5 quiet again");

        // R7/R8: readback with chain off
        frame(48'h950000, 24, 1'b1, 24'h950000, 48'd0, "R7 read request", "R5 quiet");
        frame(48'h000000, 24, 1'b1, 24'h000000, {24'd0, rdv(4'h5)}, "R2 nop", "R7 readback no chain");
        frame(48'h222222, 24, 1'b1, 24'h222222, 48'd0, "R2 plain", "R8 back to quiet");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule